// File: doc/BRIEF.md
# Per-CPU Interrupt Mask and Summary

This block gathers every interrupt source aimed at one processor into a single summary word and a single interrupt line. Four kinds of one-cycle event pulses (serial port, interprocessor call, clock tick, console halt) set sticky flags. Software clears these flags by writing ones to them. A level halt request and four priority-level I/O requests (levels 14 to 17) are reflected as read-only flags that follow their inputs. Each I/O request carries the 5-bit number of the node that raised it. That number is latched into a per-level field of the summary when the request is first seen.

A 9-bit enable mask selects which summary flags may drive the CPU interrupt line. Software reads the summary at interrupt time to find which source fired and, for I/O levels, which node to service.

Top module: `cpu_irq_summary`

## Requirements
- R1: While `rst` is high at a clock edge, the mask, all sticky flags, level flags, the halt flag and all source fields clear, so after that edge `summary` is 0, `mask_q` is 0 and `cpu_irq` is 0.
- R2: A clock edge with `wr_mask` high loads `wdata[8:0]` into the mask, seen on `mask_q` after that edge. Mask bit 0 enables the serial flag, bits 1 to 4 enable levels 14 to 17, bit 5 the interprocessor call, bit 6 the clock, bit 7 the halt and bit 8 the console halt.
- R3: A one-cycle pulse on `evt_serial`, `evt_ipi`, `evt_clock` or `evt_conhalt` sets summary bit 0, 5, 6 or 27 after the edge, and the bit stays set until it is cleared.
- R4: A clock edge with `wr_clear` high clears each sticky bit (0, 5, 6, 27) whose matching `wdata` bit is 1. Sticky bits whose `wdata` bit is 0 keep their value.
- R5: When a set pulse and a clearing write hit the same sticky bit on the same edge, the bit is set after that edge.
- R6: Summary bits 1 to 4 show `lvl_req[0]` to `lvl_req[3]` (levels 14 to 17) as sampled at the previous edge. A clearing write does not change them.
- R7: Summary bit 28 shows `halt_req` as sampled at the previous edge. A clearing write does not change it.
- R8: On the edge where the request for level 14+k is first seen high, `lvl_src[5k+4:5k]` is captured into the summary field at bits 7+5k+4 down to 7+5k (level 14 at 11:7, 15 at 16:12, 16 at 21:17, 17 at 26:22). The field holds while the request stays high even if `lvl_src` changes, and it reads 0 once the request has dropped.
- R9: `cpu_irq` is high exactly when some summary flag and its mask enable are both set. Summary bit 0 pairs with mask bit 0, bits 1 to 4 with mask bits 1 to 4, bit 5 with mask bit 5, bit 6 with mask bit 6, bit 28 with mask bit 7 and bit 27 with mask bit 8.
- R10: Summary bits 31 to 29 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mask | input | 1 | Load the mask from `wdata[8:0]` |
| wr_clear | input | 1 | Write-one-to-clear of the sticky summary bits |
| wdata | input | 32 | Write data for mask load or clear |
| evt_serial | input | 1 | Serial port event pulse |
| evt_ipi | input | 1 | Interprocessor call event pulse |
| evt_clock | input | 1 | Clock tick event pulse |
| evt_conhalt | input | 1 | Console halt event pulse |
| halt_req | input | 1 | Level halt request from configuration |
| lvl_req | input | 4 | I/O requests, bit k is level 14+k |
| lvl_src | input | 20 | Source node numbers, 5 bits per level, level 14+k at [5k+4:5k] |
| summary | output | 32 | Summary word |
| mask_q | output | 9 | Current enable mask |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
Each sticky source is pulsed on its own, so a bit-position swap between event inputs shows up. Clearing writes are given with selected ones and with ones aimed at read-only flags, which separates write-one-to-clear from a plain write. Colliding set and clear pulses show which of the two wins. For the I/O levels, the source node changes while a request is held and the request is then dropped, which tells capture-once apart from follow-the-input. One-hot masks are paired with single pending flags, which exposes any wrong pairing in the interrupt OR, including the crossed halt and console-halt enables.

// File: rtl/irqsum_pkg.sv
package irqsum_pkg;
    localparam int MASK_W   = 9;
    localparam int SUM_W    = 32;
    localparam int N_LVL    = 4;
    localparam int SRC_W    = 5;
    localparam int N_STICKY = 4;
    localparam int LVL_BIT0 = 1;
    localparam int SRC_BIT0 = 7;
    localparam int HALT_BIT = 28;
    localparam int TOP_USED = 28;

    // sticky slot order: serial, ipi, clock, console halt
    localparam int STICKY_POS [N_STICKY] = '{0, 5, 6, 27};
    localparam int STICKY_MSK [N_STICKY] = '{0, 5, 6, 8};
    localparam int HALT_MSK   = 7;

    typedef struct packed {
        logic conhalt;
        logic clock;
        logic ipi;
        logic serial;
    } evt_t;

    function automatic int src_lsb(input int k);
        return SRC_BIT0 + SRC_W * k;
    endfunction
endpackage

// File: rtl/irqsum_mask_reg.sv
module irqsum_mask_reg
    import irqsum_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MASK_W-1:0] din,
    output logic [MASK_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= din;
    end

    a_r2_mask_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(din)));
    a_r2_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/irqsum_sticky_bit.sv
module irqsum_sticky_bit (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> q);
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !q);
    a_r3_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (!set && !clr) |=> $stable(q));
endmodule

// File: rtl/irqsum_level_slot.sv
module irqsum_level_slot
    import irqsum_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [SRC_W-1:0] src,
    output logic             pend,
    output logic [SRC_W-1:0] src_q
);
    logic accept;
    assign accept = req && !pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            src_q <= '0;
        end else begin
            pend <= req;
            if (accept)   src_q <= src;
            else if (!req) src_q <= '0;
        end
    end

    a_r8_src_hold: assert property (@(posedge clk) disable iff (rst)
        (pend && req) |=> $stable(src_q));
    a_r8_src_zero: assert property (@(posedge clk) disable iff (rst)
        !pend |-> (src_q == '0));
    a_r6_follow: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(req));
endmodule

// File: rtl/cpu_irq_summary.sv
module cpu_irq_summary
    import irqsum_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_mask,
    input  logic                   wr_clear,
    input  logic [SUM_W-1:0]       wdata,
    input  logic                   evt_serial,
    input  logic                   evt_ipi,
    input  logic                   evt_clock,
    input  logic                   evt_conhalt,
    input  logic                   halt_req,
    input  logic [N_LVL-1:0]       lvl_req,
    input  logic [N_LVL*SRC_W-1:0] lvl_src,
    output logic [SUM_W-1:0]       summary,
    output logic [MASK_W-1:0]      mask_q,
    output logic                   cpu_irq
);
    evt_t                   evt;
    logic [N_STICKY-1:0]    sticky_q;
    logic [N_LVL-1:0]       pend_q;
    logic [SRC_W-1:0]       src_q [N_LVL];
    logic                   halt_q;
    logic [MASK_W-1:0]      en_vec;

    assign evt = '{conhalt: evt_conhalt, clock: evt_clock, ipi: evt_ipi, serial: evt_serial};

    irqsum_mask_reg u_mask (
        .clk (clk),
        .rst (rst),
        .load(wr_mask),
        .din (wdata[MASK_W-1:0]),
        .q   (mask_q)
    );

    for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
        irqsum_sticky_bit u_bit (
            .clk(clk),
            .rst(rst),
            .set(evt[i]),
            .clr(wr_clear && wdata[STICKY_POS[i]]),
            .q  (sticky_q[i])
        );
    end

    for (genvar k = 0; k < N_LVL; k++) begin : g_lvl
        irqsum_level_slot u_slot (
            .clk  (clk),
            .rst  (rst),
            .req  (lvl_req[k]),
            .src  (lvl_src[SRC_W*k +: SRC_W]),
            .pend (pend_q[k]),
            .src_q(src_q[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) halt_q <= 1'b0;
        else     halt_q <= halt_req;
    end

    always_comb begin
        summary = '0;
        for (int i = 0; i < N_STICKY; i++) summary[STICKY_POS[i]] = sticky_q[i];
        for (int k = 0; k < N_LVL; k++) begin
            summary[LVL_BIT0 + k]         = pend_q[k];
            summary[src_lsb(k) +: SRC_W]  = src_q[k];
        end
        summary[HALT_BIT] = halt_q;
    end

    always_comb begin
        en_vec = '0;
        for (int i = 0; i < N_STICKY; i++) en_vec[STICKY_MSK[i]] = sticky_q[i];
        for (int k = 0; k < N_LVL; k++)    en_vec[LVL_BIT0 + k]   = pend_q[k];
        en_vec[HALT_MSK] = halt_q;
    end

    assign cpu_irq = |(en_vec & mask_q);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (summary == '0 && mask_q == '0));
    a_r9_no_enable_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !cpu_irq);
    a_r10_unused_zero: assert property (@(posedge clk) disable iff (rst)
        summary[SUM_W-1:TOP_USED+1] == '0);
    a_r7_halt_follow: assert property (@(posedge clk) disable iff (rst)
        $rose(summary[HALT_BIT]) |-> $past(halt_req));
endmodule

// File: tb/sim_cpu_irq_summary.sv
module sim_cpu_irq_summary;
    logic        clk = 0;
    logic        rst;
    logic        wr_mask, wr_clear;
    logic [31:0] wdata;
    logic        evt_serial, evt_ipi, evt_clock, evt_conhalt, halt_req;
    logic [3:0]  lvl_req;
    logic [19:0] lvl_src;
    logic [31:0] summary;
    logic [8:0]  mask_q;
    logic        cpu_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cpu_irq_summary u0 (
        .clk(clk), .rst(rst), .wr_mask(wr_mask), .wr_clear(wr_clear), .wdata(wdata),
        .evt_serial(evt_serial), .evt_ipi(evt_ipi), .evt_clock(evt_clock),
        .evt_conhalt(evt_conhalt), .halt_req(halt_req), .lvl_req(lvl_req),
        .lvl_src(lvl_src), .summary(summary), .mask_q(mask_q), .cpu_irq(cpu_irq)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_mask = 0; wr_clear = 0; wdata = 0;
        evt_serial = 0; evt_ipi = 0; evt_clock = 0; evt_conhalt = 0;
    endtask

    task automatic do_reset();
        idle(); halt_req = 0; lvl_req = 0; lvl_src = 0;
        rst = 1; step(); step(); rst = 0;
    endtask

    task automatic write_mask(input logic [8:0] m);
        wr_mask = 1; wdata = {23'd0, m}; step(); idle();
    endtask

    task automatic write_clear(input logic [31:0] v);
        wr_clear = 1; wdata = v; step(); idle();
    endtask

    task automatic t_reset();
        evt_serial = 1; evt_conhalt = 1; halt_req = 1; lvl_req = 4'hF; wr_mask = 1; wdata = 32'h1FF;
        step(); idle(); step();
        do_reset();
        chk("R1 summary", summary, 0);
        chk("R1 mask", {23'd0, mask_q}, 0);
        chk("R1 irq", {31'd0, cpu_irq}, 0);
    endtask

    task automatic t_mask();
        write_mask(9'h1A5);
        chk("R2 mask load", {23'd0, mask_q}, 32'h1A5);
        step();
        chk("R2 mask hold", {23'd0, mask_q}, 32'h1A5);
        write_mask(9'h000);
    endtask

    task automatic t_sticky();
        evt_serial = 1; step(); idle(); step();
        chk("R3 serial bit0", summary, 32'h0000_0001);
        evt_ipi = 1; step(); idle();
        chk("R3 ipi bit5", summary, 32'h0000_0021);
        evt_clock = 1; step(); idle();
        chk("R3 clock bit6", summary, 32'h0000_0061);
        evt_conhalt = 1; step(); idle(); step(); step();
        chk("R3 conhalt bit27 stays", summary, 32'h0800_0061);
    endtask

    task automatic t_clear();
        write_clear(32'h0000_0020);
        chk("R4 clear ipi only", summary, 32'h0800_0041);
        write_clear(32'h0800_0041);
        chk("R4 clear rest", summary, 0);
    endtask

    task automatic t_collide();
        evt_clock = 1; step(); idle();
        evt_clock = 1; wr_clear = 1; wdata = 32'h0000_0040; step(); idle();
        chk("R5 set wins", summary, 32'h0000_0040);
        write_clear(32'h0000_0040);
        chk("R5 then clears", summary, 0);
    endtask

    task automatic t_levels();
        lvl_req = 4'b0101; lvl_src = 0;
        #1;
        chk("R6 not before edge", summary, 0);
        step();
        chk("R6 levels 14,16", summary & 32'h1E, 32'h0000_000A);
        write_clear(32'h1FFF_FFFF);
        chk("R6 clear ignored", summary & 32'h1E, 32'h0000_000A);
        lvl_req = 0; step();
        chk("R6 drop", summary, 0);
    endtask

    task automatic t_halt();
        halt_req = 1; step();
        chk("R7 halt bit28", summary, 32'h1000_0000);
        write_clear(32'h1000_0000);
        chk("R7 clear ignored", summary, 32'h1000_0000);
        halt_req = 0; step();
        chk("R7 halt drop", summary, 0);
    endtask

    task automatic t_source();
        lvl_src = {5'd21, 5'd9, 5'd30, 5'd3};
        lvl_req = 4'hF; step();
        chk("R8 fields", summary, (32'd21 << 22) | (32'd9 << 17) | (32'd30 << 12) | (32'd3 << 7) | 32'h1E);
        lvl_src = {5'd1, 5'd2, 5'd4, 5'd31}; step(); step();
        chk("R8 hold while high", summary, (32'd21 << 22) | (32'd9 << 17) | (32'd30 << 12) | (32'd3 << 7) | 32'h1E);
        lvl_req = 4'b1110; step();
        chk("R8 l14 zero on drop", summary, (32'd21 << 22) | (32'd9 << 17) | (32'd30 << 12) | 32'h1C);
        lvl_req = 4'hF; step();
        chk("R8 l14 recapture", summary[11:7], 32'd31);
        lvl_req = 0; step();
        chk("R8 all zero", summary, 0);
    endtask

    task automatic t_irq();
        evt_serial = 1; step(); idle();
        write_mask(9'h1FE);
        chk("R9 serial masked", {31'd0, cpu_irq}, 0);
        write_mask(9'h001);
        chk("R9 serial enabled", {31'd0, cpu_irq}, 1);
        write_clear(32'h1);
        chk("R9 irq drops", {31'd0, cpu_irq}, 0);
        halt_req = 1; step();
        write_mask(9'h100);
        chk("R9 halt not on conhalt en", {31'd0, cpu_irq}, 0);
        write_mask(9'h080);
        chk("R9 halt on bit7", {31'd0, cpu_irq}, 1);
        halt_req = 0; step();
        evt_conhalt = 1; step(); idle();
        chk("R9 conhalt not on bit7", {31'd0, cpu_irq}, 0);
        write_mask(9'h100);
        chk("R9 conhalt on bit8", {31'd0, cpu_irq}, 1);
        write_clear(32'h0800_0000);
        lvl_req = 4'b1000; step();
        write_mask(9'h008);
        chk("R9 l17 wrong enable", {31'd0, cpu_irq}, 0);
        write_mask(9'h010);
        chk("R9 l17 bit4", {31'd0, cpu_irq}, 1);
        lvl_req = 0; step();
        write_mask(0);
    endtask

    task automatic t_unused();
        evt_serial = 1; evt_ipi = 1; evt_clock = 1; evt_conhalt = 1;
        halt_req = 1; lvl_req = 4'hF; lvl_src = 20'hFFFFF;
        step(); idle(); step();
        chk("R10 top bits zero", {29'd0, summary[31:29]}, 0);
        chk("R10 full word", summary, 32'h1FFF_FFFF);
        halt_req = 0; lvl_req = 0; write_clear(32'hFFFF_FFFF);
        chk("R10 after clear", summary, 0);
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(); halt_req = 0; lvl_req = 0; lvl_src = 0; rst = 1;
        #5;
        t_reset();
        t_mask();
        t_sticky();
        t_clear();
        t_collide();
        t_levels();
        t_halt();
        t_source();
        t_irq();
        t_unused();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule